// File: doc/BRIEF.md
# Polarity-Steered Column Accumulator

This block is the digital back end of one column of an analog multiply array. A current-controlled oscillator, outside the block, turns the column current into a stream of pulses, and a comparator reports the sign of that current. Both arrive here already synchronized. While an integration window is open, every pulse lands in one of two saturating 12-bit counters, and the live sign flag picks the counter at the moment of the pulse. The block therefore sums positive and negative current contributions over all input timesteps in a single pass.

When the window closes, the block subtracts the negative count from the positive count. It multiplies the difference by a per-column unsigned fixed-point gain and rounds to the nearest integer. It then adds a per-column signed offset, which also cancels the contribution of the bias rows. A rectifier can optionally force negative results to zero. The value is clamped to a signed byte and held on a valid/ready output until a consumer takes it.

Top module: `colsum_top`

## Requirements
- R1: A pulse (`pulse_i` high for one cycle) that is counted goes to the positive counter when `pol_i` is 1 and to the negative counter when `pol_i` is 0, as sampled in that same cycle.
- R2: Each counter stops at 4095 and never wraps, however many further pulses arrive.
- R3: `win_start_i` clears both counters and opens the window from the next cycle. Pulses are ignored in the start cycle itself, while no window is open, and after the window has closed.
- R4: A pulse in the cycle that samples `win_end_i` is still counted. `res_valid_o` rises on the second rising edge, counting the edge that samples `win_end_i` as the first.
- R5: The result is `((P - N) * scale_i + 128) >>> 8 + offset_i`. Here `scale_i` is unsigned with 8 fraction bits, `offset_i` is a signed 16-bit integer, and `>>>` is an arithmetic shift, so halves round toward plus infinity.
- R6: When `relu_en_i` is 1 at the capture edge, a negative value becomes 0.
- R7: The output is the value clamped to -128..127 and given in two's complement on `res_data_o`.
- R8: While `res_valid_o` is 1 and `res_ready_i` is 0, `res_valid_o` and `res_data_o` stay unchanged. An edge with both high clears `res_valid_o`.
- R9: A `win_start_i` during an open window restarts it with cleared counters. A `win_end_i` while no window is open produces no result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_i | input | 1 | Synchronized oscillator pulse, one per cycle high |
| pol_i | input | 1 | Current sign flag, 1 = positive |
| win_start_i | input | 1 | Clears counters and opens the window |
| win_end_i | input | 1 | Closes the window and requests a result |
| scale_i | input | 12 | Per-column gain, unsigned, 8 fraction bits |
| offset_i | input | 16 | Per-column signed offset |
| relu_en_i | input | 1 | Rectify negative results to zero |
| res_ready_i | input | 1 | Consumer accepts the result |
| res_valid_o | output | 1 | Result available |
| res_data_o | output | 8 | Signed 8-bit result |

## Verification
Several properties are checked on every clock by the in-line assertions. Pulse steering into the selected counter, the saturation ceiling and single-step growth of each counter hold on each cycle. So do the freezing of both counters outside the window, the clearing on start, the sign of rectified results, output stability under back-pressure, and the absence of results after an orphan end. Only the bench's scenarios show the arithmetic of the final value: subtraction, rounding of halves, offset, clamping at both ends, and the exact cycle the result appears. They also show that restarts and stray pulses leave the count correct.

// File: rtl/colsum_pkg.sv
package colsum_pkg;
  localparam int CNT_W_DEF   = 12;
  localparam int SCALE_W_DEF = 12;
  localparam int FRAC_W_DEF  = 8;
  localparam int OFS_W_DEF   = 16;
  localparam int OUT_W_DEF   = 8;

  typedef enum logic {
    CNT_POS = 1'b0,
    CNT_NEG = 1'b1
  } cnt_sel_e;

  localparam int NUM_CNT = 2;
endpackage

// File: rtl/colsum_satcnt.sv
module colsum_satcnt #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] q_o
);
  localparam logic [W-1:0] MAX = '1;

  logic [W-1:0] q_q;
  logic [W-1:0] q_d;
  logic         q_en;

  always_comb begin
    q_d  = q_q;
    q_en = 1'b0;
    if (clr_i) begin
      q_d  = '0;
      q_en = 1'b1;
    end else if (inc_i && (q_q != MAX)) begin
      q_d  = q_q + 1'b1;
      q_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q <= '0;
    end else if (q_en) begin
      q_q <= q_d;
    end
  end

  assign q_o = q_q;

  // R2: ceiling is sticky
  assert_sat_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (q_q == MAX) && !clr_i |=> q_q == MAX);

  // R2: growth is at most one step per cycle
  assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> (q_q == $past(q_q)) || (q_q == $past(q_q) + 1'b1));
endmodule

// File: rtl/colsum_post.sv
module colsum_post #(
  parameter int CNT_W   = 12,
  parameter int SCALE_W = 12,
  parameter int FRAC_W  = 8,
  parameter int OFS_W   = 16,
  parameter int OUT_W   = 8
) (
  input  logic [CNT_W-1:0]   pos_i,
  input  logic [CNT_W-1:0]   neg_i,
  input  logic [SCALE_W-1:0] scale_i,
  input  logic [OFS_W-1:0]   offset_i,
  input  logic               relu_en_i,
  output logic [OUT_W-1:0]   res_o
);
  localparam int DIFF_W = CNT_W + 1;
  localparam int PROD_W = DIFF_W + SCALE_W + 1;
  localparam int SUM_W  = ((PROD_W > OFS_W) ? PROD_W : OFS_W) + 1;

  localparam logic signed [PROD_W-1:0] HALF = PROD_W'(1) << (FRAC_W - 1);
  localparam logic signed [SUM_W-1:0]  OMAX = SUM_W'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0]  OMIN = ~OMAX;

  logic signed [DIFF_W-1:0]  diff;
  logic signed [SCALE_W:0]   scl_s;
  logic signed [PROD_W-1:0]  prod;
  logic signed [PROD_W-1:0]  prod_rnd;
  logic signed [PROD_W-1:0]  shifted;
  logic signed [SUM_W-1:0]   shifted_x;
  logic signed [SUM_W-1:0]   ofs_x;
  logic signed [SUM_W-1:0]   sum;
  logic signed [SUM_W-1:0]   rect;
  logic signed [SUM_W-1:0]   clamped;

  always_comb begin
    diff      = $signed({1'b0, pos_i}) - $signed({1'b0, neg_i});
    scl_s     = $signed({1'b0, scale_i});
    prod      = diff * scl_s;
    prod_rnd  = prod + HALF;
    shifted   = prod_rnd >>> FRAC_W;
    shifted_x = $signed({{(SUM_W - PROD_W){shifted[PROD_W-1]}}, shifted});
    ofs_x     = $signed({{(SUM_W - OFS_W){offset_i[OFS_W-1]}}, offset_i});
    sum       = shifted_x + ofs_x;
    rect      = (relu_en_i && sum[SUM_W-1]) ? '0 : sum;
    if (rect > OMAX) begin
      clamped = OMAX;
    end else if (rect < OMIN) begin
      clamped = OMIN;
    end else begin
      clamped = rect;
    end
    res_o = clamped[OUT_W-1:0];
  end
endmodule

// File: rtl/colsum_top.sv
module colsum_top
  import colsum_pkg::*;
#(
  parameter int CNT_W   = CNT_W_DEF,
  parameter int SCALE_W = SCALE_W_DEF,
  parameter int FRAC_W  = FRAC_W_DEF,
  parameter int OFS_W   = OFS_W_DEF,
  parameter int OUT_W   = OUT_W_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pulse_i,
  input  logic               pol_i,
  input  logic               win_start_i,
  input  logic               win_end_i,
  input  logic [SCALE_W-1:0] scale_i,
  input  logic [OFS_W-1:0]   offset_i,
  input  logic               relu_en_i,
  input  logic               res_ready_i,
  output logic               res_valid_o,
  output logic [OUT_W-1:0]   res_data_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             win_open_q, win_open_d;
  logic             calc_q, calc_d;
  logic             vld_q, vld_d;
  logic [OUT_W-1:0] dat_q;
  logic             end_ok;
  logic             count_en;
  logic             load;
  logic [OUT_W-1:0] post_res;

  logic [CNT_W-1:0] cnt [NUM_CNT];
  logic             inc [NUM_CNT];

  // window and result control, next state
  always_comb begin
    end_ok   = win_end_i && win_open_q && !win_start_i;
    count_en = win_open_q && pulse_i && !win_start_i;
    load     = calc_q && (!vld_q || res_ready_i);

    win_open_d = win_open_q;
    if (win_start_i) begin
      win_open_d = 1'b1;
    end else if (end_ok) begin
      win_open_d = 1'b0;
    end

    calc_d = calc_q;
    if (end_ok) begin
      calc_d = 1'b1;
    end else if (load) begin
      calc_d = 1'b0;
    end

    vld_d = vld_q;
    if (load) begin
      vld_d = 1'b1;
    end else if (vld_q && res_ready_i) begin
      vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_open_q <= 1'b0;
      calc_q     <= 1'b0;
      vld_q      <= 1'b0;
    end else begin
      win_open_q <= win_open_d;
      calc_q     <= calc_d;
      vld_q      <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q <= '0;
    end else if (load) begin
      dat_q <= post_res;
    end
  end

  // steering of pulses into the two counters
  always_comb begin
    inc[CNT_POS] = count_en && pol_i;
    inc[CNT_NEG] = count_en && !pol_i;
  end

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    colsum_satcnt #(.W(CNT_W)) cnt_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (win_start_i),
      .inc_i (inc[g]),
      .q_o   (cnt[g])
    );
  end

  colsum_post #(
    .CNT_W   (CNT_W),
    .SCALE_W (SCALE_W),
    .FRAC_W  (FRAC_W),
    .OFS_W   (OFS_W),
    .OUT_W   (OUT_W)
  ) post_i (
    .pos_i     (cnt[CNT_POS]),
    .neg_i     (cnt[CNT_NEG]),
    .scale_i   (scale_i),
    .offset_i  (offset_i),
    .relu_en_i (relu_en_i),
    .res_o     (post_res)
  );

  assign res_valid_o = vld_q;
  assign res_data_o  = dat_q;

  // R1: positive pulse reaches positive counter only
  assert_steer_pos_R1: assert property (@(posedge clk) disable iff (!rst_n)
    win_open_q && pulse_i && pol_i && !win_start_i && (cnt[CNT_POS] != CNT_MAX)
    |=> (cnt[CNT_POS] == $past(cnt[CNT_POS]) + 1'b1) && $stable(cnt[CNT_NEG]));

  // R1: negative pulse reaches negative counter only
  assert_steer_neg_R1: assert property (@(posedge clk) disable iff (!rst_n)
    win_open_q && pulse_i && !pol_i && !win_start_i && (cnt[CNT_NEG] != CNT_MAX)
    |=> (cnt[CNT_NEG] == $past(cnt[CNT_NEG]) + 1'b1) && $stable(cnt[CNT_POS]));

  // R3: counters frozen while the window is shut
  assert_closed_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !win_open_q && !win_start_i |=> $stable(cnt[CNT_POS]) && $stable(cnt[CNT_NEG]));

  // R3: start clears both counters
  assert_start_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    win_start_i |=> (cnt[CNT_POS] == '0) && (cnt[CNT_NEG] == '0));

  // R6: rectified captures are never negative
  assert_relu_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load && relu_en_i |=> !res_data_o[OUT_W-1]);

  // R8: held output under back-pressure
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o && !res_ready_i |=> res_valid_o && $stable(res_data_o));

  // R9: an end with no open window yields nothing
  assert_orphan_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    win_end_i && !win_open_q && !calc_q && !res_valid_o |=> !res_valid_o);
endmodule

// File: tb/colsum_top_tb_top.sv
`timescale 1ns/1ps
module colsum_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        pulse_i, pol_i, win_start_i, win_end_i, relu_en_i, res_ready_i;
  logic [11:0] scale_i;
  logic [15:0] offset_i;
  logic        res_valid_o;
  logic [7:0]  res_data_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  colsum_top dut_i (
    .clk(clk), .rst_n(rst_n), .pulse_i(pulse_i), .pol_i(pol_i),
    .win_start_i(win_start_i), .win_end_i(win_end_i), .scale_i(scale_i),
    .offset_i(offset_i), .relu_en_i(relu_en_i), .res_ready_i(res_ready_i),
    .res_valid_o(res_valid_o), .res_data_o(res_data_o)
  );

  // np, nn, scale, offset, relu
  localparam int NV = 10;
  localparam int TV [NV][5] = '{
    '{10,   4,  256,    0, 0},
    '{ 3,   0,  128,    0, 0},
    '{ 0,   3,  128,    0, 0},
    '{50,  20,  256,  -10, 0},
    '{ 5,  40,  512,    0, 0},
    '{ 5,  40,  512,    0, 1},
    '{200,  0, 1024,    0, 0},
    '{ 0, 200, 1024,    0, 0},
    '{100, 100, 4095, 300, 0},
    '{60,   0,  300, -400, 1}
  };

  function automatic int model(int np, int nn, int sc, int ofs, int relu);
    int p, n, r;
    p = (np > 4095) ? 4095 : np;
    n = (nn > 4095) ? 4095 : nn;
    r = (((p - n) * sc) + 128) >>> 8;
    r = r + ofs;
    if (relu != 0 && r < 0) r = 0;
    if (r > 127) r = 127;
    if (r < -128) r = -128;
    return r;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setup(int sc, int ofs, int relu);
    scale_i   = sc[11:0];
    offset_i  = ofs[15:0];
    relu_en_i = relu[0];
  endtask

  task automatic pulses(int np, int nn);
    for (int k = 0; k < ((np > nn) ? np : nn); k++) begin
      if (k < np) begin pulse_i = 1'b1; pol_i = 1'b1; @(negedge clk); end
      if (k < nn) begin pulse_i = 1'b1; pol_i = 1'b0; @(negedge clk); end
      pulse_i = 1'b0;
      if (k % 3 == 0) @(negedge clk);
    end
    pulse_i = 1'b0;
  endtask

  // ends the window, checks R4 timing and the value, optionally accepts
  task automatic finish_win(int exp, string req, bit accept);
    win_end_i = 1'b1; @(negedge clk); win_end_i = 1'b0;
    chk(res_valid_o == 1'b0, "R4 not yet valid", int'(res_valid_o), 0);
    @(negedge clk);
    chk(res_valid_o == 1'b1, "R4 valid on second edge", int'(res_valid_o), 1);
    chk(int'($signed(res_data_o)) == exp, req, int'($signed(res_data_o)), exp);
    if (accept) begin
      res_ready_i = 1'b1; @(negedge clk); res_ready_i = 1'b0;
      chk(res_valid_o == 1'b0, "R8 drop after accept", int'(res_valid_o), 0);
    end
  endtask

  task automatic open_win;
    win_start_i = 1'b1; @(negedge clk); win_start_i = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int e;
    rst_n = 1'b0;
    pulse_i = 0; pol_i = 0; win_start_i = 0; win_end_i = 0;
    relu_en_i = 0; res_ready_i = 0; scale_i = 0; offset_i = 0;
    repeat (3) @(negedge clk);
    chk(res_valid_o == 1'b0, "reset valid", int'(res_valid_o), 0);
    chk(res_data_o == 8'd0, "reset data", int'(res_data_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table: R1 steering, R5 arithmetic/rounding, R6 relu, R7 clamp
    for (int v = 0; v < NV; v++) begin
      setup(TV[v][2], TV[v][3], TV[v][4]);
      open_win();
      pulses(TV[v][0], TV[v][1]);
      e = model(TV[v][0], TV[v][1], TV[v][2], TV[v][3], TV[v][4]);
      finish_win(e, "R1 R5 R6 R7 table value", 1'b1);
    end

    // R2: saturation, 4200 pulses -> 4095 -> (4095+128)>>8 = 16
    setup(1, 0, 0);
    open_win();
    pulse_i = 1'b1; pol_i = 1'b1;
    repeat (4200) @(negedge clk);
    pulse_i = 1'b0;
    finish_win(16, "R2 saturation", 1'b1);

    // R3: stray pulses outside window and in start/after-end cycles ignored
    setup(256, 33, 0);
    pulse_i = 1'b1; pol_i = 1'b1;
    repeat (20) @(negedge clk);
    win_start_i = 1'b1; @(negedge clk); win_start_i = 1'b0;
    pulse_i = 1'b0;
    pulses(4, 0);
    win_end_i = 1'b1; @(negedge clk); win_end_i = 1'b0;
    pulse_i = 1'b1;
    @(negedge clk);
    pulse_i = 1'b0;
    chk(int'($signed(res_data_o)) == 37, "R3 stray pulses ignored", int'($signed(res_data_o)), 37);
    res_ready_i = 1'b1; @(negedge clk); res_ready_i = 1'b0;

    // R4: pulse in the end cycle counts
    setup(256, 0, 0);
    open_win();
    pulses(2, 0);
    pulse_i = 1'b1; pol_i = 1'b0;
    finish_win(1, "R4 end-cycle pulse counted", 1'b1);
    pulse_i = 1'b0;

    // R9: orphan end
    win_end_i = 1'b1; @(negedge clk); win_end_i = 1'b0;
    repeat (4) @(negedge clk);
    chk(res_valid_o == 1'b0, "R9 orphan end no result", int'(res_valid_o), 0);

    // R9: restart clears, pulse in restart cycle ignored
    setup(256, 0, 0);
    open_win();
    pulses(5, 0);
    pulse_i = 1'b1; pol_i = 1'b1;
    open_win();
    pulse_i = 1'b0;
    pulses(2, 0);
    finish_win(2, "R9 restart", 1'b1);

    // R8: hold under back-pressure while inputs change
    setup(256, 0, 0);
    open_win();
    pulses(7, 0);
    finish_win(7, "R8 captured value", 1'b0);
    setup(4095, -5000, 1);
    for (int c = 0; c < 5; c++) begin
      pulse_i = 1'b1; @(negedge clk);
      chk(res_valid_o == 1'b1 && int'($signed(res_data_o)) == 7,
          "R8 held", int'($signed(res_data_o)), 7);
    end
    pulse_i = 1'b0;
    res_ready_i = 1'b1; @(negedge clk); res_ready_i = 1'b0;
    chk(res_valid_o == 1'b0, "R8 accepted", int'(res_valid_o), 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule